// File: doc/BRIEF.md
# Deferred instruction fetch abort handler

This block sits between the instruction fetch path and the execute stage of a processor. Each fetch response goes into a small in-order queue together with flags. One flag marks a synchronous fetch abort. The other marks a debug event such as a breakpoint, a vector catch or a breakpoint instruction. A flagged instruction is never reported when it is fetched. The block raises the prefetch-abort request only when that instruction reaches the head of the queue, which is the point where it would otherwise issue to execute. If the instruction is discarded before that point, for example by a redirect or by another exception entry, its flag goes with it and nothing is reported.

On exception entry the block latches two values. The saved status word is a copy of the current status word. The link value is formed from the program-counter view the instruction would have seen, which is its address plus 4 in the compact instruction set and plus 8 in the wide one. The block then subtracts 0 in compact state and 4 in wide state. Either way the link value is the faulting address plus 4. The request stays asserted until the execute stage acknowledges it, and every younger queued instruction is dropped at entry. An asynchronous fetch abort takes a separate path: it produces a one-cycle data-abort request and never a prefetch-abort request.

Top module: `ifetch_abort_defer`

## Requirements
- R1: After reset, `pabt_req`, `dabt_req` and `ex_valid` are 0 and `fq_ready` is 1.
- R2: Instructions without flags leave through `ex_valid`/`ex_addr` in fetch order, one for each cycle in which `ex_valid` and `ex_ready` are both 1, and neither abort request is raised.
- R3: A response with `fq_abort`=1 and `fq_async`=0 raises no request while younger than the queue head. Once it is the head, `ex_valid` is 0 and `pabt_req` rises one clock edge later.
- R4: `flush` empties the whole queue at one clock edge, and the flags of the flushed entries never raise `pabt_req`. This holds even when `flush` coincides with a flagged head, and the response offered in the flush cycle is discarded.
- R5: An accepted response with `fq_abort`=1 and `fq_async`=1 makes `dabt_req` 1 for exactly the following cycle. It is queued without a flag and later issues normally, with no `pabt_req`.
- R6: A response with `fq_dbg`=1 raises `pabt_req` in the same way as a synchronous abort once it is the head.
- R7: `saved_status` equals the `cur_status` value of the entry cycle and stays constant while `pabt_req` is held, whatever `cur_status` does in that time.
- R8: `link_addr` is the flagged instruction's address plus 4, both when status bit TBIT (bit 5 by default) is 1 (compact state) and when it is 0 (wide state).
- R9: `pabt_req` stays 1 until a cycle with `pabt_ack`=1 and is 0 from the following cycle on.
- R10: The oldest flagged instruction wins. At entry every younger entry and the response offered in the entry cycle are dropped, so that after the acknowledge there is no second request and the queue is empty.
- R11: The queue holds DEPTH (4) entries. `fq_ready` is 0 while the queue is full or a request is pending, and a response offered while `fq_ready` is 0 is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fq_valid | input | 1 | Fetch response present |
| fq_ready | output | 1 | Queue can take a response |
| fq_addr | input | AW | Address of the fetched instruction |
| fq_abort | input | 1 | Fetch was aborted |
| fq_async | input | 1 | Abort is asynchronous (only when fq_abort=1) |
| fq_dbg | input | 1 | Debug event attached to this instruction |
| flush | input | 1 | Discard all queued instructions |
| ex_valid | output | 1 | Head instruction offered to execute |
| ex_addr | output | AW | Address of the offered instruction |
| ex_ready | input | 1 | Execute takes the offered instruction |
| cur_status | input | SW | Current status word, bit TBIT is the compact-state bit |
| pabt_req | output | 1 | Prefetch-abort exception request |
| pabt_ack | input | 1 | Execute acknowledges the request |
| saved_status | output | SW | Status word saved at entry |
| link_addr | output | AW | Link value computed at entry |
| dabt_req | output | 1 | Data-abort request for an asynchronous fetch abort |

## Verification
The main function is driven with several input patterns. A flagged instruction queued behind a clean one shows whether reporting waits for the head or happens at fetch. A flush that lands while the flagged entry is still younger, and another that lands on the exact cycle the flagged entry becomes head, check whether a dropped flag can still escape. An asynchronous abort checks that the two abort paths are kept apart, and a debug flag with a compact-state status word checks the second trigger and the other link formula. Two flagged entries queued back to back check that the older one wins and that the younger one is discarded rather than reported after the acknowledge.

// File: rtl/ifd_pkg.sv
package ifd_pkg;

   // Per-entry flags kept alongside each queued instruction
   typedef struct packed {
      logic sync_abt;   // synchronous fetch abort, deferred
      logic async_abt;  // asynchronous fetch abort, already reported
      logic dbg_evt;    // breakpoint / vector catch / breakpoint instruction
   } ifd_tag_t;

   // A flag that must turn into a prefetch-abort exception at the head
   function automatic logic ifd_raises(input ifd_tag_t t);
      return t.sync_abt | t.dbg_evt;
   endfunction

   // Build the entry flags from one fetch response
   function automatic ifd_tag_t ifd_make_tag(input logic abort, input logic async_t,
                                             input logic dbg);
      ifd_tag_t t;
      t.sync_abt  = abort & ~async_t;
      t.async_abt = abort & async_t;
      t.dbg_evt   = dbg;
      return t;
   endfunction

endpackage

// File: rtl/ifd_queue.sv
module ifd_queue
   import ifd_pkg::*;
#(
   parameter int AW    = 32,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          push,
   input  logic [AW-1:0] push_addr,
   input  ifd_tag_t      push_tag,
   input  logic          pop,
   output logic          head_valid,
   output logic [AW-1:0] head_addr,
   output ifd_tag_t      head_tag,
   output logic          full
);

   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = PW + 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("ifd_queue: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [AW-1:0] addr_mem [DEPTH];
   ifd_tag_t      tag_mem  [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] count;

   logic do_push, do_pop;
   assign do_push = push & ~full & ~clear;
   assign do_pop  = pop & head_valid & ~clear;

   assign head_valid = (count != '0);
   assign full       = (count == CW'(DEPTH));
   assign head_addr  = addr_mem[rd_ptr];
   assign head_tag   = tag_mem[rd_ptr];

   // One storage slot per generate iteration
   generate
      for (genvar s = 0; s < DEPTH; s++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               addr_mem[s] <= '0;
               tag_mem[s]  <= '0;
            end else if (do_push && wr_ptr == PW'(s)) begin
               addr_mem[s] <= push_addr;
               tag_mem[s]  <= push_tag;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clear) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + PW'(1);
         if (do_pop)  rd_ptr <= rd_ptr + PW'(1);
         case ({do_push, do_pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/ifd_link_calc.sv
module ifd_link_calc #(
   parameter int AW         = 32,
   parameter int COMPACT_PC = 4,  // PC view offset in compact state
   parameter int WIDE_PC    = 8   // PC view offset in wide state
) (
   input  logic [AW-1:0] inst_addr,
   input  logic          compact,
   output logic [AW-1:0] link
);

   localparam int COMPACT_ADJ = COMPACT_PC - 4;
   localparam int WIDE_ADJ    = WIDE_PC - 4;

   generate
      if (COMPACT_ADJ < 0 || WIDE_ADJ < 0) begin : g_bad_off
         $error("ifd_link_calc: PC view offsets must be at least 4");
      end
   endgenerate

   logic [AW-1:0] pc_view;

   // The PC the instruction would observe, then the per-state correction
   always_comb begin
      pc_view = inst_addr + (compact ? AW'(COMPACT_PC) : AW'(WIDE_PC));
      link    = pc_view - (compact ? AW'(COMPACT_ADJ) : AW'(WIDE_ADJ));
   end

endmodule

// File: rtl/ifd_exc_ctrl.sv
module ifd_exc_ctrl #(
   parameter int AW = 32,
   parameter int SW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          head_flagged,
   input  logic          flush,
   input  logic          ack,
   input  logic [SW-1:0] cur_status,
   input  logic [AW-1:0] link_in,
   output logic          take,
   output logic          pending,
   output logic [SW-1:0] saved_status,
   output logic [AW-1:0] link_addr
);

   // Entry happens only when nothing is outstanding and no flush cancels it
   assign take = head_flagged & ~pending & ~flush;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending      <= 1'b0;
         saved_status <= '0;
         link_addr    <= '0;
      end else if (take) begin
         pending      <= 1'b1;
         saved_status <= cur_status;
         link_addr    <= link_in;
      end else if (pending && ack) begin
         pending      <= 1'b0;
      end
   end

endmodule

// File: rtl/ifetch_abort_defer.sv
module ifetch_abort_defer
   import ifd_pkg::*;
#(
   parameter int AW    = 32,
   parameter int SW    = 32,
   parameter int DEPTH = 4,
   parameter int TBIT  = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fq_valid,
   output logic          fq_ready,
   input  logic [AW-1:0] fq_addr,
   input  logic          fq_abort,
   input  logic          fq_async,
   input  logic          fq_dbg,
   input  logic          flush,
   output logic          ex_valid,
   output logic [AW-1:0] ex_addr,
   input  logic          ex_ready,
   input  logic [SW-1:0] cur_status,
   output logic          pabt_req,
   input  logic          pabt_ack,
   output logic [SW-1:0] saved_status,
   output logic [AW-1:0] link_addr,
   output logic          dabt_req
);

   generate
      if (TBIT >= SW) begin : g_bad_tbit
         $error("ifetch_abort_defer: TBIT outside status word");
      end
      if (AW < 4) begin : g_bad_aw
         $error("ifetch_abort_defer: AW too small");
      end
   endgenerate

   logic          head_valid, q_full, pend, take, head_flagged, push, pop;
   logic [AW-1:0] head_addr, link_calc;
   ifd_tag_t      head_tag;
   logic          dabt_q;

   assign fq_ready     = ~q_full & ~pend;
   assign push         = fq_valid & fq_ready & ~flush;
   assign head_flagged = head_valid & ifd_raises(head_tag);
   assign ex_valid     = head_valid & ~ifd_raises(head_tag) & ~pend & ~flush;
   assign ex_addr      = head_addr;
   assign pop          = ex_valid & ex_ready;
   assign pabt_req     = pend;
   assign dabt_req     = dabt_q;

   ifd_queue #(.AW(AW), .DEPTH(DEPTH)) queue_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (flush | take),
      .push       (push),
      .push_addr  (fq_addr),
      .push_tag   (ifd_make_tag(fq_abort, fq_async, fq_dbg)),
      .pop        (pop),
      .head_valid (head_valid),
      .head_addr  (head_addr),
      .head_tag   (head_tag),
      .full       (q_full)
   );

   ifd_link_calc #(.AW(AW)) link_i (
      .inst_addr (head_addr),
      .compact   (cur_status[TBIT]),
      .link      (link_calc)
   );

   ifd_exc_ctrl #(.AW(AW), .SW(SW)) exc_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .head_flagged (head_flagged),
      .flush        (flush),
      .ack          (pabt_ack),
      .cur_status   (cur_status),
      .link_in      (link_calc),
      .take         (take),
      .pending      (pend),
      .saved_status (saved_status),
      .link_addr    (link_addr)
   );

   // Asynchronous fetch aborts are reported at once on the data-abort path
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dabt_q <= 1'b0;
      else        dabt_q <= push & fq_abort & fq_async;
   end

endmodule

// File: rtl/ifd_chk.sv
module ifd_chk #(
   parameter int AW = 32,
   parameter int SW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          fq_valid,
   input logic          fq_ready,
   input logic          fq_abort,
   input logic          fq_async,
   input logic          flush,
   input logic          ex_valid,
   input logic          pabt_req,
   input logic          pabt_ack,
   input logic [SW-1:0] saved_status,
   input logic [AW-1:0] link_addr,
   input logic          dabt_req,
   input logic [AW-1:0] head_addr
);

   // R9
   pabt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pabt_req && !pabt_ack |=> pabt_req);

   // R9
   pabt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pabt_req && pabt_ack |=> !pabt_req);

   // R7
   saved_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pabt_req && !pabt_ack |=> $stable(saved_status) && $stable(link_addr));

   // R3
   no_issue_in_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ex_valid && pabt_req));

   // R5
   dabt_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dabt_req |-> $past(fq_valid && fq_ready && !flush && fq_abort && fq_async));

   // R11
   no_accept_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pabt_req |-> !fq_ready);

   // R8
   link_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pabt_req) |-> link_addr == $past(head_addr) + AW'(4));

endmodule

bind ifetch_abort_defer ifd_chk #(.AW(AW), .SW(SW)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .fq_valid     (fq_valid),
   .fq_ready     (fq_ready),
   .fq_abort     (fq_abort),
   .fq_async     (fq_async),
   .flush        (flush),
   .ex_valid     (ex_valid),
   .pabt_req     (pabt_req),
   .pabt_ack     (pabt_ack),
   .saved_status (saved_status),
   .link_addr    (link_addr),
   .dabt_req     (dabt_req),
   .head_addr    (head_addr)
);

// File: tb/ifetch_abort_defer_tb_top.sv
`timescale 1ns/1ps
module ifetch_abort_defer_tb_top;

   localparam int AW = 32;
   localparam int SW = 32;
   localparam logic [SW-1:0] ST_WIDE    = 32'h0000_0010; // bit 5 = 0
   localparam logic [SW-1:0] ST_COMPACT = 32'h0000_0030; // bit 5 = 1

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fq_valid = 1'b0, fq_abort = 1'b0, fq_async = 1'b0, fq_dbg = 1'b0;
   logic [AW-1:0] fq_addr = '0;
   logic          flush = 1'b0, ex_ready = 1'b0, pabt_ack = 1'b0;
   logic [SW-1:0] cur_status = ST_WIDE;
   logic          fq_ready, ex_valid, pabt_req, dabt_req;
   logic [AW-1:0] ex_addr, link_addr;
   logic [SW-1:0] saved_status;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   ifetch_abort_defer dut_i (
      .clk(clk), .rst_n(rst_n), .fq_valid(fq_valid), .fq_ready(fq_ready),
      .fq_addr(fq_addr), .fq_abort(fq_abort), .fq_async(fq_async), .fq_dbg(fq_dbg),
      .flush(flush), .ex_valid(ex_valid), .ex_addr(ex_addr), .ex_ready(ex_ready),
      .cur_status(cur_status), .pabt_req(pabt_req), .pabt_ack(pabt_ack),
      .saved_status(saved_status), .link_addr(link_addr), .dabt_req(dabt_req)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Offer one response for one cycle (called and returning at a falling edge)
   task automatic put(input logic [AW-1:0] a, input logic ab, input logic as_t,
                      input logic dbg);
      fq_valid = 1'b1; fq_addr = a; fq_abort = ab; fq_async = as_t; fq_dbg = dbg;
      @(negedge clk);
      fq_valid = 1'b0; fq_abort = 1'b0; fq_async = 1'b0; fq_dbg = 1'b0;
   endtask

   task automatic pop1();
      ex_ready = 1'b1;
      @(negedge clk);
      ex_ready = 1'b0;
   endtask

   task automatic ack1();
      pabt_ack = 1'b1;
      @(negedge clk);
      pabt_ack = 1'b0;
   endtask

   task automatic do_flush();
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "pabt_req", 64'(pabt_req), 64'd0);
      chk("R1", "dabt_req", 64'(dabt_req), 64'd0);
      chk("R1", "ex_valid", 64'(ex_valid), 64'd0);
      chk("R1", "fq_ready", 64'(fq_ready), 64'd1);
   endtask

   task automatic t_plain();
      put(32'h100, 0, 0, 0); put(32'h104, 0, 0, 0); put(32'h108, 0, 0, 0);
      for (int i = 0; i < 3; i++) begin
         chk("R2", "ex_valid", 64'(ex_valid), 64'd1);
         chk("R2", "ex_addr", 64'(ex_addr), 64'(32'h100 + 4*i));
         chk("R2", "pabt_req", 64'(pabt_req | dabt_req), 64'd0);
         pop1();
      end
      chk("R2", "ex_valid empty", 64'(ex_valid), 64'd0);
   endtask

   task automatic t_full();
      for (int i = 0; i < 4; i++) put(32'h200 + 32'(4*i), 0, 0, 0);
      chk("R11", "fq_ready full", 64'(fq_ready), 64'd0);
      put(32'h2F0, 0, 0, 0);
      for (int i = 0; i < 4; i++) begin
         chk("R11", "ex_addr order", 64'(ex_addr), 64'(32'h200 + 4*i));
         pop1();
      end
      chk("R11", "extra dropped", 64'(ex_valid), 64'd0);
   endtask

   task automatic t_defer();
      cur_status = ST_WIDE;
      put(32'h400, 0, 0, 0);
      put(32'h480, 1, 0, 0);
      chk("R3", "no request behind head", 64'(pabt_req), 64'd0);
      chk("R3", "clean head issues", 64'(ex_valid), 64'd1);
      pop1();
      chk("R3", "flagged head not issued", 64'(ex_valid), 64'd0);
      chk("R3", "request one edge later", 64'(pabt_req), 64'd0);
      @(negedge clk);
      chk("R3", "request raised", 64'(pabt_req), 64'd1);
      chk("R8", "link wide", 64'(link_addr), 64'(32'h484));
      chk("R7", "saved status", 64'(saved_status), 64'(ST_WIDE));
      cur_status = 32'hFFFF_0000;
      repeat (3) @(negedge clk);
      chk("R9", "request held", 64'(pabt_req), 64'd1);
      chk("R7", "saved stable", 64'(saved_status), 64'(ST_WIDE));
      chk("R11", "not ready while pending", 64'(fq_ready), 64'd0);
      ack1();
      chk("R9", "request dropped", 64'(pabt_req), 64'd0);
      cur_status = ST_WIDE;
   endtask

   task automatic t_debug();
      cur_status = ST_COMPACT;
      put(32'h2002, 0, 0, 1);
      @(negedge clk);
      chk("R6", "debug request", 64'(pabt_req), 64'd1);
      chk("R8", "link compact", 64'(link_addr), 64'(32'h2006));
      chk("R7", "saved compact", 64'(saved_status), 64'(ST_COMPACT));
      ack1();
      cur_status = ST_WIDE;
   endtask

   task automatic t_async();
      put(32'h600, 1, 1, 0);
      chk("R5", "dabt_req pulse", 64'(dabt_req), 64'd1);
      chk("R5", "issues normally", 64'(ex_valid), 64'd1);
      @(negedge clk);
      chk("R5", "dabt_req one cycle", 64'(dabt_req), 64'd0);
      chk("R5", "no prefetch abort", 64'(pabt_req), 64'd0);
      chk("R5", "ex_addr", 64'(ex_addr), 64'(32'h600));
      pop1();
   endtask

   task automatic t_flush_young();
      put(32'h700, 0, 0, 0);
      put(32'h704, 1, 0, 0);
      do_flush();
      chk("R4", "queue empty", 64'(ex_valid), 64'd0);
      repeat (2) @(negedge clk);
      chk("R4", "dropped flag silent", 64'(pabt_req), 64'd0);
      chk("R4", "ready again", 64'(fq_ready), 64'd1);
   endtask

   task automatic t_flush_head();
      put(32'h800, 1, 0, 0);
      flush = 1'b1; fq_valid = 1'b1; fq_addr = 32'h804;
      @(negedge clk);
      flush = 1'b0; fq_valid = 1'b0;
      chk("R4", "flush beats entry", 64'(pabt_req), 64'd0);
      chk("R4", "flush-cycle response dropped", 64'(ex_valid), 64'd0);
      @(negedge clk);
      chk("R4", "still silent", 64'(pabt_req), 64'd0);
   endtask

   task automatic t_priority();
      put(32'h900, 0, 0, 0);
      put(32'h300, 1, 0, 0);
      put(32'h340, 0, 0, 1);
      pop1();
      fq_valid = 1'b1; fq_addr = 32'h9F0;
      @(negedge clk);
      fq_valid = 1'b0;
      chk("R10", "older wins", 64'(link_addr), 64'(32'h304));
      chk("R10", "request", 64'(pabt_req), 64'd1);
      ack1();
      repeat (2) @(negedge clk);
      chk("R10", "no second request", 64'(pabt_req), 64'd0);
      chk("R10", "younger dropped", 64'(ex_valid), 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_plain();
      t_full();
      t_defer();
      t_debug();
      t_async();
      t_flush_young();
      t_flush_head();
      t_priority();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule